// File: doc/BRIEF.md
# Eight-bit Timer with Compare Match and Interrupt Flags

This block is a small timer. It holds a counter that steps once for each pulse on a count-tick input, and an 8-bit compare value that software writes. It can run in two ways. In saw-tooth mode the counter climbs from zero to its top value and wraps. In triangle mode the counter climbs to the top, turns, and falls back to zero before it climbs again. Two sticky flags record the events the counter produces. One flag is set when the counter equals the compare value. The other is set when the counter wraps, or in triangle mode when it turns at the bottom.

Software reaches the block through a small register port. A write strobe, an address and write data update the compare value, the enable mask and the flags. Read data is returned in the same cycle from the address applied. Each flag drives an interrupt request. A request is raised only when the flag is set, its mask bit is set and the global interrupt enable input is high. An interrupt controller takes a handler through a one-hot acknowledge input, which clears the flag of that vector.

The block has no data stream, so it has no valid/ready handshake. The register port accepts a write in any cycle with the strobe high and never holds off. All of its pins are plain control and status signals.

Top module: `tcmp_top`

## Requirements
- R1: In saw-tooth mode (`phase_mode`=0) the counter, read at address 3, rises by one on each cycle with `cnt_tick` high and goes from 0xFF back to 0x00. With `cnt_tick` low it holds its value. Writes to address 3 have no effect.
- R2: In triangle mode (`phase_mode`=1) the counter climbs to 0xFF and then moves to 0xFE. It falls to 0x00 and then moves to 0x01. Each turn takes one tick.
- R3: On a tick where the counter equals the compare value, flag bit 1 (flag register, address 2) becomes one after that clock edge.
- R4: In saw-tooth mode, the tick that wraps the counter from 0xFF to 0x00 sets flag bit 0.
- R5: In triangle mode, flag bit 0 is set by the tick that turns the counter upward at 0x00. It is never set by the turn at 0xFF.
- R6: A register write to address 2 clears each flag whose data bit is one. A data bit of zero leaves that flag unchanged.
- R7: `vec_ack` is one-hot: bit 1 acknowledges the compare vector and bit 0 the overflow vector. Each bit clears only its own flag.
- R8: If a flag's set event and a clear (write-one or acknowledge) fall in the same cycle, the flag ends up set.
- R9: `irq_cmp` equals `gie` AND mask bit 1 AND flag bit 1. `irq_ovf` equals `gie` AND mask bit 0 AND flag bit 0.
- R10: In the mask register (address 1) and the flag register (address 2), bits 7 to 2 always read zero, whatever was written to them.
- R11: After reset the compare value, mask, flags and counter read zero, and both interrupt requests are low.
- R12: Address 0 reads back the last compare value written. Address 1 reads back bits 1 (compare enable) and 0 (overflow enable) of the last mask write. A compare value written in a cycle is first used for matching on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count enable pulse, one step per high cycle |
| phase_mode | input | 1 | 0 = saw-tooth wrap, 1 = triangle up/down |
| gie | input | 1 | Global interrupt enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 compare, 1 mask, 2 flags, 3 counter |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, same cycle |
| vec_ack | input | 2 | One-hot vector acknowledge: bit 1 compare, bit 0 overflow |
| irq_cmp | output | 1 | Compare match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default 8-bit width. At that width one full saw-tooth period is 256 ticks and one triangle period is 510 ticks, so a few thousand cycles cover many wraps and both turns in each direction. Short compare values such as 0x05 let the bench time a write-one clear or an acknowledge to land in the exact cycle of a set event, to check that the set wins. Moving the compare value to 0xFF and to 0x00 puts a match on the turns in triangle mode.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef enum logic [1:0] {
    RA_CMP   = 2'd0,
    RA_MASK  = 2'd1,
    RA_FLAG  = 2'd2,
    RA_COUNT = 2'd3
  } reg_addr_e;

  localparam int NUM_VEC = 2;
  localparam int VEC_OVF = 0;
  localparam int VEC_CMP = 1;
endpackage

// File: rtl/tcmp_counter.sv
module tcmp_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         phase_mode,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output logic         match_evt,
  output logic         ovf_evt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = '0;

  logic dir_down;
  logic at_top, at_bot;

  assign at_top = (count == TOP);
  assign at_bot = (count == BOT);

  always_comb begin
    match_evt = tick && (count == cmp_val);
    if (phase_mode) ovf_evt = tick && dir_down && at_bot;
    else            ovf_evt = tick && at_top;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      dir_down <= 1'b0;
    end else if (tick) begin
      if (!phase_mode) begin
        count    <= count + 1'b1;
        dir_down <= 1'b0;
      end else if (!dir_down) begin
        if (at_top) begin
          dir_down <= 1'b1;
          count    <= count - 1'b1;
        end else begin
          count    <= count + 1'b1;
        end
      end else begin
        if (at_bot) begin
          dir_down <= 1'b0;
          count    <= count + 1'b1;
        end else begin
          count    <= count - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tcmp_flags.sv
module tcmp_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gie,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] wclr_vec,
  input  logic [N-1:0] ack_vec,
  input  logic [N-1:0] en_vec,
  output logic [N-1:0] flags,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rst_n)                       flags[i] <= 1'b0;
      else if (set_vec[i])              flags[i] <= 1'b1;
      else if (wclr_vec[i] | ack_vec[i]) flags[i] <= 1'b0;
    end
    assign irq[i] = gie & en_vec[i] & flags[i];
  end
endmodule

// File: rtl/tcmp_regs.sv
module tcmp_regs #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cmp_val,
  output logic [N-1:0] mask
);
  import tcmp_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_val <= '0;
      mask    <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_CMP:  cmp_val <= wr_data;
        RA_MASK: mask    <= wr_data[N-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_tick,
  input  logic         phase_mode,
  input  logic         gie,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [1:0]   vec_ack,
  output logic         irq_cmp,
  output logic         irq_ovf
);
  import tcmp_pkg::*;

  localparam int N   = NUM_VEC;
  localparam int PAD = W - N;

  logic [W-1:0] cnt_q, cmp_q;
  logic [N-1:0] mask_q, flag_q, set_v, wclr_v, irq_v;
  logic         match_e, ovf_e;

  tcmp_regs #(.W(W), .N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .cmp_val(cmp_q), .mask(mask_q)
  );

  tcmp_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .phase_mode(phase_mode),
    .cmp_val(cmp_q), .count(cnt_q), .match_evt(match_e), .ovf_evt(ovf_e)
  );

  always_comb begin
    set_v          = '0;
    set_v[VEC_CMP] = match_e;
    set_v[VEC_OVF] = ovf_e;
    wclr_v = (reg_we && reg_addr == RA_FLAG) ? reg_wdata[N-1:0] : '0;
  end

  tcmp_flags #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n), .gie(gie), .set_vec(set_v),
    .wclr_vec(wclr_v), .ack_vec(vec_ack), .en_vec(mask_q),
    .flags(flag_q), .irq(irq_v)
  );

  assign irq_cmp = irq_v[VEC_CMP];
  assign irq_ovf = irq_v[VEC_OVF];

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_CMP:  reg_rdata = cmp_q;
      RA_MASK: reg_rdata = {{PAD{1'b0}}, mask_q};
      RA_FLAG: reg_rdata = {{PAD{1'b0}}, flag_q};
      default: reg_rdata = cnt_q;
    endcase
  end
endmodule

// File: rtl/tcmp_checker.sv
module tcmp_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_tick,
  input logic         phase_mode,
  input logic         gie,
  input logic         reg_we,
  input logic [1:0]   reg_addr,
  input logic         wd_cmp_bit,
  input logic [W-1:0] reg_rdata,
  input logic [1:0]   vec_ack,
  input logic         irq_cmp,
  input logic         irq_ovf,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_val,
  input logic [1:0]   flags
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic hit;
  assign hit = cnt_tick && (count == cmp_val);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(count));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !phase_mode) |=> (count == W'($past(count) + 1'b1)));

  assert_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flags[1]);

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !phase_mode && count == TOP) |=> flags[0]);

  assert_no_top_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && phase_mode && count == TOP && !flags[0]) |=> !flags[0]);

  assert_wr1_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2 && wd_cmp_bit && !hit) |=> !flags[1]);

  assert_ack_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack[1] && !hit) |=> !flags[1]);

  assert_ack_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack[0] && !cnt_tick) |=> !flags[0]);

  assert_irq_cmp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp |-> (gie && flags[1]));

  assert_irq_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> (gie && flags[0]));

  assert_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1 || reg_addr == 2'd2) |-> (reg_rdata[W-1:2] == '0));
endmodule

bind tcmp_top tcmp_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .phase_mode(phase_mode),
  .gie(gie), .reg_we(reg_we), .reg_addr(reg_addr), .wd_cmp_bit(reg_wdata[1]),
  .reg_rdata(reg_rdata), .vec_ack(vec_ack), .irq_cmp(irq_cmp),
  .irq_ovf(irq_ovf), .count(cnt_q), .cmp_val(cmp_q), .flags(flag_q)
);

// File: tb/test_tcmp_top.sv
`timescale 1ns/1ps
module test_tcmp_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b0, phase_mode = 1'b0, gie = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] vec_ack = 2'b00;
  logic       irq_cmp, irq_ovf;

  int checks = 0, errors = 0;
  bit rot_en = 1'b0;

  // behavioural reference state
  int m_cnt = 0, m_cmp = 0, m_msk = 0, m_flg = 0;
  bit m_down = 1'b0;

  always #2.5 clk = ~clk;

  tcmp_top i_tcmp_top (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .phase_mode(phase_mode),
    .gie(gie), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vec_ack(vec_ack), .irq_cmp(irq_cmp),
    .irq_ovf(irq_ovf)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_msk = 0; m_flg = 0; m_down = 1'b0;
    end else begin
      int setv, clr;
      setv = 0;
      if (cnt_tick && m_cnt == m_cmp) setv |= 2;
      if (cnt_tick && (phase_mode ? (m_down && m_cnt == 0) : (m_cnt == 255))) setv |= 1;
      clr = (reg_we && reg_addr == 2'd2) ? int'(reg_wdata) & 3 : 0;
      m_flg = ((m_flg & ~clr & ~int'(vec_ack)) | setv) & 3;
      if (reg_we && reg_addr == 2'd0) m_cmp = int'(reg_wdata);
      if (reg_we && reg_addr == 2'd1) m_msk = int'(reg_wdata) & 3;
      if (cnt_tick) begin
        if (!phase_mode) begin m_cnt = (m_cnt + 1) % 256; m_down = 1'b0; end
        else if (!m_down) begin
          if (m_cnt == 255) begin m_down = 1'b1; m_cnt = 254; end else m_cnt++;
        end else begin
          if (m_cnt == 0) begin m_down = 1'b0; m_cnt = 1; end else m_cnt--;
        end
      end
    end
  end

  task automatic expect_eq(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic int model_read(logic [1:0] a);
    case (a)
      2'd0: return m_cmp;
      2'd1: return m_msk;
      2'd2: return m_flg;
      default: return m_cnt;
    endcase
  endfunction

  // one clock, then compare every observable output with the model
  task automatic cyc();
    string tg;
    @(negedge clk);
    case (reg_addr)
      2'd0: tg = "R12 compare readback";
      2'd1: tg = "R10 mask readback";
      2'd2: tg = "R3 flag readback";
      default: tg = "R1 counter readback";
    endcase
    expect_eq(int'(reg_rdata), model_read(reg_addr), tg);
    expect_eq(int'(irq_cmp), int'(gie && m_msk[1] && m_flg[1]), "R9 irq_cmp");
    expect_eq(int'(irq_ovf), int'(gie && m_msk[0] && m_flg[0]), "R9 irq_ovf");
    if (rot_en && !reg_we) reg_addr = reg_addr + 2'd1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wait_cnt(int v);
    while (m_cnt != v) cyc();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    // R11: reset values at every address
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      cyc();
      expect_eq(int'(reg_rdata), 0, "R11 reset value");
    end
    expect_eq(int'(irq_cmp) + int'(irq_ovf), 0, "R11 irq low after reset");

    // R12 / R10: readback and reserved bits
    wr(2'd0, 8'h10);
    wr(2'd1, 8'hFF);
    reg_addr = 2'd1; cyc();
    expect_eq(int'(reg_rdata), 3, "R10 reserved mask bits");
    reg_addr = 2'd0; cyc();
    expect_eq(int'(reg_rdata), 8'h10, "R12 compare readback");
    wr(2'd3, 8'h77);
    reg_addr = 2'd3; cyc();
    expect_eq(int'(reg_rdata), 0, "R1 counter write ignored");

    // R1/R3/R4/R9: saw-tooth counting with rotating reads
    gie = 1'b1; cnt_tick = 1'b1; rot_en = 1'b1;
    run(600);
    cnt_tick = 1'b0; run(10);
    cnt_tick = 1'b1;
    gie = 1'b0; run(40); gie = 1'b1;
    rot_en = 1'b0;
    reg_addr = 2'd2; cyc();
    expect_eq(int'(reg_rdata), 3, "R4 both flags set after wraps");
    wr(2'd2, 8'hFC);
    reg_addr = 2'd2; cyc();
    expect_eq(int'(reg_rdata[1:0]), m_flg, "R6 zero bits keep flags");

    // R8: write-one clear collides with a compare match
    wr(2'd0, 8'h05);
    wait_cnt(5);
    wr(2'd2, 8'h02);
    reg_addr = 2'd2; cyc();
    expect_eq(int'(reg_rdata[1]), 1, "R8 set beats write clear");
    // R6: write one clears away from an event
    wr(2'd2, 8'h02);
    reg_addr = 2'd2; cyc();
    expect_eq(int'(reg_rdata[1]), 0, "R6 write one clears");

    // R8: acknowledge collides with a match
    wait_cnt(5);
    vec_ack = 2'b10; cyc(); vec_ack = 2'b00;
    reg_addr = 2'd2; cyc();
    expect_eq(int'(reg_rdata[1]), 1, "R8 set beats acknowledge");

    // R7: acknowledge clears only its own vector
    wait_cnt(250); run(8);
    cnt_tick = 1'b0;
    vec_ack = 2'b01; cyc(); vec_ack = 2'b00;
    reg_addr = 2'd2; cyc();
    expect_eq(int'(reg_rdata), 2, "R7 ack overflow keeps compare flag");
    vec_ack = 2'b10; cyc(); vec_ack = 2'b00;
    reg_addr = 2'd2; cyc();
    expect_eq(int'(reg_rdata), 0, "R7 ack compare clears it");

    // R2/R5: triangle mode
    cnt_tick = 1'b1; phase_mode = 1'b1;
    wr(2'd0, 8'hFF);
    wait_cnt(255); cyc();
    reg_addr = 2'd3; cyc();
    expect_eq(int'(reg_rdata), 8'hFD, "R2 turn at top");
    expect_eq(m_flg & 1, 0, "R5 no overflow at top (model)");
    reg_addr = 2'd2; cyc();
    expect_eq(int'(reg_rdata[0]), 0, "R5 no overflow at top");
    wait_cnt(0); cyc();
    reg_addr = 2'd3; cyc();
    expect_eq(int'(reg_rdata), 2, "R2 turn at bottom");
    reg_addr = 2'd2; cyc();
    expect_eq(int'(reg_rdata[0]), 1, "R5 overflow at bottom turn");
    wr(2'd0, 8'h00);
    rot_en = 1'b1;
    run(1200);
    phase_mode = 1'b0; run(300);
    phase_mode = 1'b1; run(300);
    rot_en = 1'b0;

    // R11: reset mid-run returns to zero
    rst_n = 1'b0; cyc(); rst_n = 1'b1; cnt_tick = 1'b0;
    reg_addr = 2'd1; cyc();
    expect_eq(int'(reg_rdata), 0, "R11 mask cleared by reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule